// File: doc/BRIEF.md
# Digital Integrating Current-Loop Controller

This block is one channel of a digital bias-current regulator. It chooses the code sent to a bias DAC. In open-loop mode the host supplies that code directly. In closed-loop mode an integrator supplies it. On each update tick, the integrator adds the difference between a ramped target code and the most recent sensed-current code from the ADC. When the sensed current matches the target, the error is zero and the DAC code stops moving.

A clamp request forces a preset clamp code onto the DAC on the next clock. It also withdraws the channel's conversion request and freezes the integrator. Because the integrator keeps its state, releasing the clamp returns the output to the value it had before the clamp. The update tick comes from a clock-cycle counter, with a default of 200 µs at 125 MHz. The tick is also brought out so the ADC side can schedule conversions around it.

Top module: `curloop_ctrl`

## Requirements
- R1: After reset, `dac_code` is 0, the integrator holds 0 and no sample is pending.
- R2: When `loop_en` is 0 and `clamp_req` is 0, `dac_code` equals the `host_code` of the previous clock.
- R3: When `loop_en` is 1, on an update tick with a fresh sample pending, the integrator becomes its old value plus (`target_code` − held ADC code). `dac_code` shows the integrator one clock after it changes.
- R4: A pulse on `adc_valid` latches `adc_code` as the fresh sample. A tick consumes it. A tick with no fresh sample leaves the integrator unchanged.
- R5: All codes are unsigned 12-bit straight binary. The integrator saturates at 0 and 4095 and never wraps around.
- R6: While `clamp_req` is 1, `dac_code` equals the `clamp_code` of the previous clock, and `adc_req` is 0 one clock later.
- R7: While clamped, the integrator is frozen and `adc_valid` pulses are ignored. After release in closed-loop mode, `dac_code` returns to the pre-clamp integrator value.
- R8: `update_tick` is a one-cycle pulse that repeats every `TICK_CYC` clocks.
- R9: In open-loop mode the integrator holds its value even when samples and ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_en | input | 1 | 1 selects closed-loop, 0 selects open-loop |
| clamp_req | input | 1 | Clamp request |
| clamp_code | input | 12 | Code driven while clamped |
| host_code | input | 12 | Host DAC code used in open-loop mode |
| target_code | input | 12 | Ramped target current code |
| adc_code | input | 12 | Sensed-current code from the ADC |
| adc_valid | input | 1 | Strobe qualifying `adc_code` |
| adc_req | output | 1 | Current-sense conversion request (low while clamped) |
| update_tick | output | 1 | Integrator update tick pulse |
| dac_code | output | 12 | Registered DAC code |

## Verification
The bench drives the integrator to both rails. A design that wrapped around would jump from near 4095 to a small code, or from 0 to a large one. It fires ticks with no fresh sample, which catches a design that reuses a stale sample and keeps accumulating. It sends samples while clamped and while in open-loop mode, then checks that the output returns to the exact held value. A design that leaks state during a clamp or in open-loop mode would come back at a shifted code. It also checks that the clamp code appears after one clock and that the conversion request drops.

// File: rtl/curloop_pkg.sv
package curloop_pkg;
  typedef enum logic [1:0] {
    SRC_HOST  = 2'd0,
    SRC_LOOP  = 2'd1,
    SRC_CLAMP = 2'd2
  } out_src_e;
endpackage

// File: rtl/curloop_tick.sv
module curloop_tick #(
  parameter int TICK_CYC = 25000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R8: the tick is a single-cycle pulse
  p_tick_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R8: the tick comes right after the counter wraps to zero
  p_tick_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt == '0));
endmodule

// File: rtl/curloop_integ.sv
module curloop_integ #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              loop_en,
  input  logic              clamp,
  input  logic [CODE_W-1:0] target,
  input  logic [CODE_W-1:0] adc_code,
  input  logic              adc_valid,
  output logic [CODE_W-1:0] acc
);
  localparam int SW = CODE_W + 2;
  localparam logic signed [SW-1:0] MAXC = SW'((1 << CODE_W) - 1);

  logic [CODE_W-1:0]        held;
  logic                     fresh;
  logic signed [SW-1:0]     sum;
  logic [CODE_W-1:0]        sat;

  always_comb begin
    sum = $signed({2'b00, acc}) + $signed({2'b00, target}) - $signed({2'b00, held});
    if (sum < 0)          sat = '0;
    else if (sum > MAXC)  sat = {CODE_W{1'b1}};
    else                  sat = sum[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= '0;
      fresh <= 1'b0;
      acc   <= '0;
    end else if (clamp) begin
      fresh <= 1'b0;
    end else begin
      if (adc_valid) begin
        held  <= adc_code;
        fresh <= 1'b1;
      end else if (upd) begin
        fresh <= 1'b0;
      end
      if (upd && fresh && loop_en) acc <= sat;
    end
  end

  // R4: no tick or no fresh sample, no integrator movement
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!upd || !fresh) |=> $stable(acc));
  // R7: clamp freezes the integrator
  p_clamp_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    clamp |=> $stable(acc));
  // R9: open-loop mode holds the integrator
  p_open_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !loop_en |=> $stable(acc));
  // R5: positive error never lowers the integrator (no wraparound)
  p_no_wrap_up_r5: assert property (@(posedge clk) disable iff (rst)
    (upd && fresh && loop_en && !clamp && target >= held) |=> acc >= $past(acc));
  // R5: negative error never raises the integrator
  p_no_wrap_dn_r5: assert property (@(posedge clk) disable iff (rst)
    (upd && fresh && loop_en && !clamp && target <= held) |=> acc <= $past(acc));
endmodule

// File: rtl/curloop_outsel.sv
module curloop_outsel
  import curloop_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loop_en,
  input  logic              clamp,
  input  logic [CODE_W-1:0] clamp_code,
  input  logic [CODE_W-1:0] host_code,
  input  logic [CODE_W-1:0] acc,
  output logic              adc_req,
  output logic [CODE_W-1:0] dac_code
);
  out_src_e src;

  always_comb begin
    if (clamp)        src = SRC_CLAMP;
    else if (loop_en) src = SRC_LOOP;
    else              src = SRC_HOST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code <= '0;
      adc_req  <= 1'b0;
    end else begin
      adc_req <= !clamp;
      case (src)
        SRC_CLAMP: dac_code <= clamp_code;
        SRC_LOOP:  dac_code <= acc;
        default:   dac_code <= host_code;
      endcase
    end
  end

  // R6: the clamp code reaches the output after one clock
  p_clamp_out_r6: assert property (@(posedge clk) disable iff (rst)
    clamp |=> dac_code == $past(clamp_code));
  // R6: conversion requests stop while clamped
  p_clamp_req_r6: assert property (@(posedge clk) disable iff (rst)
    clamp |=> !adc_req);
  // R2: open-loop output follows the host code
  p_open_out_r2: assert property (@(posedge clk) disable iff (rst)
    (!clamp && !loop_en) |=> dac_code == $past(host_code));
endmodule

// File: rtl/curloop_ctrl.sv
module curloop_ctrl #(
  parameter int CODE_W   = 12,
  parameter int TICK_CYC = 25000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loop_en,
  input  logic              clamp_req,
  input  logic [CODE_W-1:0] clamp_code,
  input  logic [CODE_W-1:0] host_code,
  input  logic [CODE_W-1:0] target_code,
  input  logic [CODE_W-1:0] adc_code,
  input  logic              adc_valid,
  output logic              adc_req,
  output logic              update_tick,
  output logic [CODE_W-1:0] dac_code
);
  logic [CODE_W-1:0] acc;

  curloop_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (update_tick)
  );

  curloop_integ #(.CODE_W(CODE_W)) u_integ (
    .clk       (clk),
    .rst       (rst),
    .upd       (update_tick),
    .loop_en   (loop_en),
    .clamp     (clamp_req),
    .target    (target_code),
    .adc_code  (adc_code),
    .adc_valid (adc_valid),
    .acc       (acc)
  );

  curloop_outsel #(.CODE_W(CODE_W)) u_out (
    .clk        (clk),
    .rst        (rst),
    .loop_en    (loop_en),
    .clamp      (clamp_req),
    .clamp_code (clamp_code),
    .host_code  (host_code),
    .acc        (acc),
    .adc_req    (adc_req),
    .dac_code   (dac_code)
  );
endmodule

// File: tb/test_curloop_ctrl.sv
module test_curloop_ctrl;
  localparam int TCYC = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loop_en = 1'b0, clamp_req = 1'b0, adc_valid = 1'b0;
  logic [11:0] clamp_code = '0, host_code = '0, target_code = '0, adc_code = '0;
  logic        adc_req, update_tick;
  logic [11:0] dac_code;

  typedef struct {
    int          sel;   // 0: dac_code, 1: adc_req, 2: tick period
    int          exp;
    string       tag;
  } exp_t;

  exp_t  q[$];
  event  chk_ev;
  int    checks = 0, failures = 0, period = 0;
  bit    done = 0;

  always #4 clk = ~clk;

  curloop_ctrl #(.CODE_W(12), .TICK_CYC(TCYC)) i_curloop_ctrl (
    .clk(clk), .rst(rst), .loop_en(loop_en), .clamp_req(clamp_req),
    .clamp_code(clamp_code), .host_code(host_code), .target_code(target_code),
    .adc_code(adc_code), .adc_valid(adc_valid), .adc_req(adc_req),
    .update_tick(update_tick), .dac_code(dac_code)
  );

  task automatic expect_val(int sel, int exp, string tag);
    exp_t e;
    e.sel = sel; e.exp = exp; e.tag = tag;
    q.push_back(e);
    -> chk_ev;
    #0;
  endtask

  initial begin : monitor
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        int   act;
        e = q.pop_front();
        act = (e.sel == 0) ? int'(dac_code) : (e.sel == 1) ? int'(adc_req) : period;
        checks++;
        if (act != e.exp) begin
          failures++;
          $display("FAIL %s actual=%0d expected=%0d", e.tag, act, e.exp);
        end
      end
    end
  end

  task automatic after_tick();
    do @(negedge clk); while (!update_tick);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic feed(int v);
    adc_code  = 12'(v);
    adc_valid = 1'b1;
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_val(0, 0, "R1 reset dac");

    host_code = 12'h5A5;
    @(negedge clk);
    expect_val(0, 12'h5A5, "R2 open-loop host code");
    expect_val(1, 1, "R6 request high unclamped");

    // R9: samples and ticks in open loop leave integrator at 0
    target_code = 12'd900;
    feed(0);
    after_tick();
    expect_val(0, 12'h5A5, "R9 open-loop output");

    // R8: tick period
    do @(negedge clk); while (!update_tick);
    period = 0;
    do begin @(negedge clk); period++; end while (!update_tick);
    expect_val(2, TCYC, "R8 tick period");

    loop_en = 1'b1;
    @(negedge clk);
    expect_val(0, 0, "R9 integrator held in open loop");

    target_code = 12'd1000;
    feed(0);
    after_tick();
    expect_val(0, 1000, "R3 first step");
    feed(400);
    after_tick();
    expect_val(0, 1600, "R3 second step");
    after_tick();
    expect_val(0, 1600, "R4 no fresh sample");
    feed(1000);
    after_tick();
    expect_val(0, 1600, "R3 steady state");

    target_code = 12'd4095;
    feed(0);
    after_tick();
    expect_val(0, 4095, "R5 saturate high");
    target_code = 12'd0;
    feed(4095);
    after_tick();
    expect_val(0, 0, "R5 saturate low");
    target_code = 12'd2000;
    feed(0);
    after_tick();
    expect_val(0, 2000, "R3 recover from rail");

    // clamp
    clamp_code = 12'h123;
    clamp_req  = 1'b1;
    @(negedge clk);
    expect_val(0, 12'h123, "R6 clamp code");
    expect_val(1, 0, "R6 request dropped");
    feed(0);
    after_tick();
    expect_val(0, 12'h123, "R7 still clamped");
    clamp_req = 1'b0;
    @(negedge clk);
    expect_val(0, 2000, "R7 pre-clamp value restored");
    after_tick();
    expect_val(0, 2000, "R7 clamped sample ignored");

    loop_en   = 1'b0;
    host_code = 12'h0F0;
    @(negedge clk);
    expect_val(0, 12'h0F0, "R2 back to host code");
    loop_en = 1'b1;
    @(negedge clk);
    expect_val(0, 2000, "R9 loop value kept");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule